// File: doc/BRIEF.md
# Quiet Floating-Point Comparator

This block compares two IEEE-754 operands, both single precision (32-bit) or both double precision (64-bit), and returns a one-bit predicate for one of three conditions: equal, greater-than or greater-or-equal. Single-precision operands sit in the low 32 bits of the 64-bit operand buses, and the upper bits are ignored. A caller that needs less-than or less-or-equal swaps the operands.

Every comparison is quiet. A NaN on either side, quiet or signalling, makes the predicate false, and the flag vector that goes to the status logic is always zero. When a valid request arrives, the predicate and an output valid are registered and appear one cycle later.

Top module: `qfcmp_top`

## Requirements
- R1: The output valid `res_vld` is high exactly in the cycle after a cycle with `req_vld` high, and is low out of reset.
- R2: Condition select `cond` = 2'b00 gives equal. With non-NaN operands the predicate is true when the values are equal.
- R3: `cond` = 2'b01 gives greater-than. With non-NaN operands the predicate is true when operand A is strictly greater than operand B under signed IEEE ordering, with infinities as the extreme values.
- R4: `cond` = 2'b10 gives greater-or-equal. With non-NaN operands this is the OR of greater-than and equal.
- R5: If either operand is NaN (exponent all ones, fraction nonzero), the predicate is false for all three conditions.
- R6: +0 and -0 compare equal, so equal and greater-or-equal are true between them and greater-than is false.
- R7: `is_dbl` = 0 compares the low 32 bits as single precision and ignores bits 63:32. `is_dbl` = 1 compares all 64 bits as double precision.
- R8: `flags` is all zero in every cycle, including for NaN operands.
- R9: `cond` = 2'b11 is reserved and gives a false predicate.
- R10: `pred` is zero out of reset and holds its value in cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| cond | input | 2 | Condition: 00 eq, 01 gt, 10 ge, 11 reserved |
| is_dbl | input | 1 | 1 for double, 0 for single precision |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| res_vld | output | 1 | Result strobe, one cycle after req_vld |
| pred | output | 1 | Predicate result |
| flags | output | 5 | Exception flag update, always zero |

## Verification
On every cycle the assertions check the one-cycle valid timing, that the flag vector is zero, that a NaN request or a reserved condition gives a false predicate, that greater-than and equal are never both true, and that the predicate holds between requests. Which condition is true for a given pair of ordered operands can only be seen through the bench's directed scenarios. These cover signed zeros, infinities, negative ordering, both precisions and garbage in the upper bits of single-precision operands.

// File: rtl/qfcmp_pkg.sv
package qfcmp_pkg;
  typedef enum logic [1:0] {
    COND_EQ  = 2'b00,
    COND_GT  = 2'b01,
    COND_GE  = 2'b10,
    COND_RSV = 2'b11
  } cond_e;

  typedef struct packed {
    logic is_nan;
    logic is_zero;
    logic sign;
  } opclass_t;

  localparam int FLAG_W = 5;
endpackage

// File: rtl/qfcmp_classify.sv
module qfcmp_classify #(
  parameter int EXP_W = 8,
  parameter int FRC_W = 23,
  localparam int W = 1 + EXP_W + FRC_W
) (
  input  logic [W-1:0]          val,
  output qfcmp_pkg::opclass_t   cls
);
  logic [EXP_W-1:0] expo;
  logic [FRC_W-1:0] frac;

  always_comb begin
    expo = val[W-2 -: EXP_W];
    frac = val[FRC_W-1:0];
    cls.sign    = val[W-1];
    cls.is_nan  = (&expo) && (|frac);
    cls.is_zero = ~|val[W-2:0];
  end
endmodule

// File: rtl/qfcmp_order.sv
module qfcmp_order #(
  parameter int EXP_W = 8,
  parameter int FRC_W = 23,
  localparam int W = 1 + EXP_W + FRC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         any_nan,
  output logic         eq,
  output logic         gt
);
  qfcmp_pkg::opclass_t ca, cb;
  logic mag_gt, mag_eq;

  qfcmp_classify #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_cla (.val(a), .cls(ca));
  qfcmp_classify #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_clb (.val(b), .cls(cb));

  always_comb begin
    mag_gt  = a[W-2:0] > b[W-2:0];
    mag_eq  = a[W-2:0] == b[W-2:0];
    any_nan = ca.is_nan | cb.is_nan;
    eq = 1'b0;
    gt = 1'b0;
    if (ca.is_zero && cb.is_zero) begin
      eq = 1'b1;
    end else if (ca.sign != cb.sign) begin
      gt = ~ca.sign;
    end else if (mag_eq) begin
      eq = 1'b1;
    end else begin
      gt = ca.sign ? ~mag_gt : mag_gt;
    end
  end
endmodule

// File: rtl/qfcmp_top.sv
module qfcmp_top #(
  parameter int SP_EXP = 8,
  parameter int SP_FRC = 23,
  parameter int DP_EXP = 11,
  parameter int DP_FRC = 52,
  localparam int SP_W = 1 + SP_EXP + SP_FRC,
  localparam int DP_W = 1 + DP_EXP + DP_FRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [1:0]      cond,
  input  logic            is_dbl,
  input  logic [DP_W-1:0] opa,
  input  logic [DP_W-1:0] opb,
  output logic            res_vld,
  output logic            pred,
  output logic [qfcmp_pkg::FLAG_W-1:0] flags
);
  import qfcmp_pkg::*;

  logic s_nan, s_eq, s_gt, d_nan, d_eq, d_gt;
  logic sel_nan, sel_eq, sel_gt;
  logic pred_nxt, pred_q, vld_q;

  qfcmp_order #(.EXP_W(SP_EXP), .FRC_W(SP_FRC)) u_sp (
    .a(opa[SP_W-1:0]), .b(opb[SP_W-1:0]),
    .any_nan(s_nan), .eq(s_eq), .gt(s_gt));

  qfcmp_order #(.EXP_W(DP_EXP), .FRC_W(DP_FRC)) u_dp (
    .a(opa), .b(opb),
    .any_nan(d_nan), .eq(d_eq), .gt(d_gt));

  always_comb begin
    sel_nan = is_dbl ? d_nan : s_nan;
    sel_eq  = is_dbl ? d_eq  : s_eq;
    sel_gt  = is_dbl ? d_gt  : s_gt;
    pred_nxt = 1'b0;
    if (!sel_nan) begin
      unique case (cond_e'(cond))
        COND_EQ:  pred_nxt = sel_eq;
        COND_GT:  pred_nxt = sel_gt;
        COND_GE:  pred_nxt = sel_gt | sel_eq;
        default:  pred_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pred_q <= 1'b0;
    end else begin
      vld_q <= req_vld;
      if (req_vld) pred_q <= pred_nxt;
    end
  end

  assign res_vld = vld_q;
  assign pred    = pred_q;
  assign flags   = '0;
endmodule

// File: rtl/qfcmp_checker.sv
module qfcmp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic [1:0]  cond,
  input logic        is_dbl,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        res_vld,
  input logic        pred,
  input logic [4:0]  flags,
  input logic        s_eq,
  input logic        s_gt,
  input logic        d_eq,
  input logic        d_gt
);
  logic nan_in;
  always_comb begin
    if (is_dbl)
      nan_in = ((&opa[62:52]) && (|opa[51:0])) || ((&opb[62:52]) && (|opb[51:0]));
    else
      nan_in = ((&opa[30:23]) && (|opa[22:0])) || ((&opb[30:23]) && (|opb[22:0]));
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld);
  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld);
  assert_gt_eq_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_gt && s_eq) && !(d_gt && d_eq));
  assert_nan_false_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && nan_in) |=> !pred);
  assert_flags_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags == 5'd0);
  assert_reserved_false_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && cond == 2'b11) |=> !pred);
  assert_pred_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> $stable(pred));
endmodule

bind qfcmp_top qfcmp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .cond(cond), .is_dbl(is_dbl),
  .opa(opa), .opb(opb), .res_vld(res_vld), .pred(pred), .flags(flags),
  .s_eq(s_eq), .s_gt(s_gt), .d_eq(d_eq), .d_gt(d_gt));

// File: tb/qfcmp_top_test.sv
module qfcmp_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0;
  logic [1:0] cond = 2'b00;
  logic is_dbl = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic res_vld, pred;
  logic [4:0] flags;
  int checks = 0, errors = 0;

  localparam logic [31:0] S_ONE = 32'h3f80_0000, S_TWO = 32'h4000_0000;
  localparam logic [31:0] S_NEG1 = 32'hbf80_0000, S_NEG2 = 32'hc000_0000;
  localparam logic [31:0] S_PINF = 32'h7f80_0000, S_NINF = 32'hff80_0000;
  localparam logic [31:0] S_QNAN = 32'h7fc0_0000, S_SNAN = 32'h7f80_0001;
  localparam logic [31:0] S_NZ = 32'h8000_0000, S_MAX = 32'h7f7f_ffff;
  localparam logic [63:0] D_ONE = 64'h3ff0_0000_0000_0000, D_ANY = 64'h3f80_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7ff8_0000_0000_0000, D_NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_NINF = 64'hfff0_0000_0000_0000;

  qfcmp_top uut (.clk(clk), .rst_n(rst_n), .req_vld(req_vld), .cond(cond),
    .is_dbl(is_dbl), .opa(opa), .opb(opb), .res_vld(res_vld), .pred(pred), .flags(flags));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cmp(input string req, input logic [1:0] c, input logic dbl,
                     input logic [63:0] a, input logic [63:0] b, input logic exp);
    @(negedge clk);
    req_vld = 1'b1; cond = c; is_dbl = dbl; opa = a; opb = b;
    @(negedge clk);
    req_vld = 1'b0;
    chk({req, " valid"}, res_vld, 1'b1);
    chk(req, pred, exp);
    chk({req, " flags"}, |flags, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", res_vld, 1'b0);
    chk("R10 reset pred", pred, 1'b0);
    chk("R8 reset flags", |flags, 1'b0);
  endtask

  task automatic t_equal;
    cmp("R2 eq same", 2'b00, 1'b0, {32'h0, S_ONE}, {32'h0, S_ONE}, 1'b1);
    cmp("R2 eq diff", 2'b00, 1'b0, {32'h0, S_ONE}, {32'h0, S_TWO}, 1'b0);
    cmp("R2 eq inf", 2'b00, 1'b0, {32'h0, S_NINF}, {32'h0, S_NINF}, 1'b1);
  endtask

  task automatic t_greater;
    cmp("R3 gt pos", 2'b01, 1'b0, {32'h0, S_TWO}, {32'h0, S_ONE}, 1'b1);
    cmp("R3 gt pos rev", 2'b01, 1'b0, {32'h0, S_ONE}, {32'h0, S_TWO}, 1'b0);
    cmp("R3 gt neg", 2'b01, 1'b0, {32'h0, S_NEG1}, {32'h0, S_NEG2}, 1'b1);
    cmp("R3 gt neg rev", 2'b01, 1'b0, {32'h0, S_NEG2}, {32'h0, S_NEG1}, 1'b0);
    cmp("R3 gt mixed", 2'b01, 1'b0, {32'h0, S_ONE}, {32'h0, S_NEG2}, 1'b1);
    cmp("R3 gt inf", 2'b01, 1'b0, {32'h0, S_PINF}, {32'h0, S_MAX}, 1'b1);
    cmp("R3 gt ninf", 2'b01, 1'b0, {32'h0, S_NINF}, {32'h0, S_NEG2}, 1'b0);
    cmp("R3 gt equal", 2'b01, 1'b0, {32'h0, S_ONE}, {32'h0, S_ONE}, 1'b0);
  endtask

  task automatic t_ge;
    cmp("R4 ge eq", 2'b10, 1'b0, {32'h0, S_ONE}, {32'h0, S_ONE}, 1'b1);
    cmp("R4 ge gt", 2'b10, 1'b0, {32'h0, S_TWO}, {32'h0, S_NEG1}, 1'b1);
    cmp("R4 ge lt", 2'b10, 1'b0, {32'h0, S_NEG2}, {32'h0, S_NEG1}, 1'b0);
  endtask

  task automatic t_nan;
    for (int c = 0; c < 3; c++) begin
      cmp("R5 sp qnan a", 2'(c), 1'b0, {32'h0, S_QNAN}, {32'h0, S_ONE}, 1'b0);
      cmp("R5 sp snan b", 2'(c), 1'b0, {32'h0, S_ONE}, {32'h0, S_SNAN}, 1'b0);
      cmp("R5 sp nan nan", 2'(c), 1'b0, {32'h0, S_QNAN}, {32'h0, S_QNAN}, 1'b0);
      cmp("R5 dp nan", 2'(c), 1'b1, D_QNAN, D_ANY, 1'b0);
    end
    cmp("R8 flags on nan", 2'b00, 1'b1, D_QNAN, D_QNAN, 1'b0);
  endtask

  task automatic t_zero;
    cmp("R6 eq zeros", 2'b00, 1'b0, 64'h0, {32'h0, S_NZ}, 1'b1);
    cmp("R6 ge zeros", 2'b10, 1'b0, {32'h0, S_NZ}, 64'h0, 1'b1);
    cmp("R6 gt zeros", 2'b01, 1'b0, 64'h0, {32'h0, S_NZ}, 1'b0);
    cmp("R6 dp eq zeros", 2'b00, 1'b1, D_NZ, 64'h0, 1'b1);
  endtask

  task automatic t_precision;
    cmp("R7 sp upper ignored", 2'b00, 1'b0, {32'hdead_beef, S_ONE}, {32'h1234_5678, S_ONE}, 1'b1);
    cmp("R7 sp upper nan ignored", 2'b00, 1'b0, {32'h7ff8_0000, S_TWO}, {32'h0, S_TWO}, 1'b1);
    cmp("R7 dp eq", 2'b00, 1'b1, D_ONE, D_ONE, 1'b1);
    cmp("R7 dp full width", 2'b00, 1'b1, D_ONE, D_ONE | 64'h1, 1'b0);
    cmp("R7 dp gt", 2'b01, 1'b1, D_ONE, D_ANY, 1'b1);
    cmp("R7 dp ninf", 2'b01, 1'b1, D_NINF, D_NZ, 1'b0);
  endtask

  task automatic t_reserved;
    cmp("R9 reserved eq vals", 2'b11, 1'b0, {32'h0, S_ONE}, {32'h0, S_ONE}, 1'b0);
    cmp("R9 reserved gt vals", 2'b11, 1'b1, D_ONE, D_ANY, 1'b0);
  endtask

  task automatic t_hold;
    cmp("R10 set true", 2'b00, 1'b0, {32'h0, S_ONE}, {32'h0, S_ONE}, 1'b1);
    @(negedge clk);
    cond = 2'b01; opa = '0; opb = {32'h0, S_ONE};
    @(negedge clk);
    chk("R10 hold pred", pred, 1'b1);
    chk("R1 idle valid", res_vld, 1'b0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_equal();
    t_greater();
    t_ge();
    t_nan();
    t_zero();
    t_precision();
    t_reserved();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule